// File: doc/BRIEF.md
# Match-Based PWM Timer with Deferred Compare Update

A multi-channel pulse-width modulation timer. A programmable prescaler divides the
block clock into timer ticks, and each tick advances a period counter. The compare
value in slot 0 defines the period: the counter runs from 0 up to one below that
value and then restarts. Slots 1 to NUM_CH each drive one output channel. A channel
runs in single-edge mode by default. Even-numbered channels can also run in dual-edge
mode, where a pair of neighbouring slots places both the rising and the falling edge.

Software writes compare values into shadow registers. A shadow value is staged, not
applied. It moves into the active compare register only when its arm bit is set and the
counter then wraps at the end of a period. The arm bits clear themselves at that wrap.
This keeps every period glitch-free while software updates several compare values. A
control register starts and stops the counter, turns PWM output on or off, and can hold
the counter in a cleared state. A second control register holds per-channel enable and
mode bits. All configuration arrives over a simple write-only register port.

Top module: `pwm_match_timer`

## Requirements
- R1: While the run bit (bit 0 of the timer control register, address 0) is 1 and the clear bit is 0, the counter advances once every DIV+1 clock cycles. DIV is the prescale value written to address 1.
- R2: With active period value P (compare slot 0), `tc_value` counts 0, 1, …, P-1 and then returns to 0. With P = 0, `tc_value` stays at 0.
- R3: A write to compare slot i (address 8+i) only loads a shadow register. The active value changes only at the first counter wrap after arm bit i has been set, either by writing a 1 to bit i at address 3 or earlier. The arm bits clear at that wrap, so later shadow writes do not apply until the bit is set again.
- R4: In single-edge mode, output channel k (pin `pwm_out[k-1]`, k = 1..NUM_CH) is high while the count is below active slot k and low otherwise.
- R5: In single-edge mode, an active slot value of 0 keeps the channel low for the whole period. A value at or above the active period keeps it high for the whole period.
- R6: When dual-edge bit 8+k-1 of the channel control register (address 2) is set for an even channel k, the output is high while the count is at or above active slot k-1 and below active slot k. The dual-edge bit of an odd channel has no effect.
- R7: An output is low whenever the PWM enable bit (bit 1 of address 0) is 0 or its channel enable bit (bit k-1 of address 2) is 0. With the run bit at 0, the counter holds its value.
- R8: While the clear bit (bit 2 of address 0) is 1, the counter and the prescaler are held at zero. After release, the first count step comes DIV+1 cycles later.
- R9: Writes to unused addresses (4 to 7, and addresses above the last compare slot) change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 4 | Register address |
| wr_data | input | CNT_W | Register write data |
| pwm_out | output | NUM_CH | PWM outputs, bit k-1 is channel k |
| tc_value | output | CNT_W | Current period counter value |

## Verification
The bench targets the wrap boundary. A design that applies a shadow value on the write
itself, or one cycle off the wrap, shows a wrong duty cycle within that period. A design
that forgets to clear the arm bits applies later unarmed writes. Compare values of 0, and
values equal to or above the period, are driven to expose off-by-one comparators, which
leave a one-tick glitch where the output should be flat. Dual-edge bits are also set on
odd channels, where they must be ignored. The clear bit is released with a prescale above
zero, so that a prescaler left uncleared shows up as an early first count.

// File: rtl/pwm_match_pkg.sv
package pwm_match_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADR_TCTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_PRESC  = 4'h1;
  localparam logic [ADDR_W-1:0] ADR_CHCTL  = 4'h2;
  localparam logic [ADDR_W-1:0] ADR_ARM    = 4'h3;
  localparam logic [ADDR_W-1:0] ADR_SLOT0  = 4'h8;

  localparam int CHCTL_DUAL_LSB = 8;

  typedef struct packed {
    logic clr;
    logic pwm_en;
    logic run;
  } tctrl_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pc_q;
  logic             wrap;

  assign wrap   = (pc_q >= div_i);
  assign tick_o = run_i && !clr_i && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= '0;
    else if (clr_i)  pc_q <= '0;
    else if (run_i)  pc_q <= wrap ? '0 : pc_q + 1'b1;
  end

  // R8: clear holds the prescaler at zero
  a_r8_presc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (pc_q == '0));
  // R7: a stopped prescaler keeps its phase
  a_r7_presc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(pc_q));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] tc_o,
  output logic             roll_o
);
  logic [CNT_W-1:0] tc_q;
  logic [CNT_W:0]   nxt;

  assign nxt    = {1'b0, tc_q} + 1'b1;
  assign roll_o = tick_i && (nxt >= {1'b0, period_i});
  assign tc_o   = tc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tc_q <= '0;
    else if (clr_i)   tc_q <= '0;
    else if (roll_o)  tc_q <= '0;
    else if (tick_i)  tc_q <= nxt[CNT_W-1:0];
  end

  // R2: the count never leaves the active period window
  a_r2_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_q == '0) || (tc_q < period_i));
  // R1: without a prescaler tick the count is frozen
  a_r1_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(tc_q));
  // R8: clear forces the counter to zero
  a_r8_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (tc_q == '0));
endmodule

// File: rtl/pwm_slot_bank.sv
module pwm_slot_bank
  import pwm_match_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NUM_SLOTS = 7
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [CNT_W-1:0]                 wr_data,
  input  logic                             roll_i,
  output logic [NUM_SLOTS-1:0][CNT_W-1:0]  act_o
);
  logic [NUM_SLOTS-1:0]            arm_q;
  logic [NUM_SLOTS-1:0]            arm_set;
  logic                            arm_wr;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] shd_q;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] act_q;

  assign arm_wr  = wr_en && (wr_addr == ADR_ARM);
  assign arm_set = arm_wr ? wr_data[NUM_SLOTS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= '0;
    else        arm_q <= (roll_i ? '0 : arm_q) | arm_set;
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_ADR = ADDR_W'(int'(ADR_SLOT0) + i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                shd_q[i] <= '0;
      else if (wr_en && (wr_addr == SLOT_ADR))   shd_q[i] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   act_q[i] <= '0;
      else if (roll_i && arm_q[i])  act_q[i] <= shd_q[i];
    end
  end

  assign act_o = act_q;

  // R3: active compare values move only at a period wrap
  a_r3_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !roll_i |=> $stable(act_q));
  // R3: arm bits are consumed by the wrap
  a_r3_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_i && !arm_wr) |=> (arm_q == '0));
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 6
) (
  input  logic [CNT_W-1:0]              tc_i,
  input  logic [NUM_CH:0][CNT_W-1:0]    act_i,
  input  logic                          pwm_en_i,
  input  logic [NUM_CH-1:0]             ch_en_i,
  input  logic [NUM_CH-1:0]             dual_i,
  output logic [NUM_CH-1:0]             pwm_o
);
  for (genvar k = 1; k <= NUM_CH; k++) begin : g_ch
    localparam bit DUAL_OK = ((k % 2) == 0);
    logic below_hi;
    logic lvl;

    assign below_hi = (tc_i < act_i[k]);

    if (DUAL_OK) begin : g_dual
      logic at_lo;
      assign at_lo = (tc_i >= act_i[k-1]);
      assign lvl   = dual_i[k-1] ? (at_lo && below_hi) : below_hi;
    end else begin : g_single
      logic dual_req;
      assign dual_req = dual_i[k-1] && DUAL_OK;
      assign lvl      = dual_req ? 1'b0 : below_hi;
    end

    assign pwm_o[k-1] = pwm_en_i && ch_en_i[k-1] && lvl;
  end

  // R7: gated channels are low
  always_comb begin
    a_r7_gate: assert ((pwm_o & ~ch_en_i) == '0);
  end
endmodule

// File: rtl/pwm_match_timer.sv
module pwm_match_timer
  import pwm_match_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  output logic [NUM_CH-1:0]    pwm_out,
  output logic [CNT_W-1:0]     tc_value
);
  localparam int NUM_SLOTS = NUM_CH + 1;

  tctrl_t                          tctrl_q;
  logic [PRE_W-1:0]                div_q;
  logic [NUM_CH-1:0]               ch_en_q;
  logic [NUM_CH-1:0]               dual_q;
  logic                            tick;
  logic                            roll;
  logic [CNT_W-1:0]                tc;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tctrl_q <= '0;
      div_q   <= '0;
      ch_en_q <= '0;
      dual_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_TCTRL: tctrl_q <= tctrl_t'(wr_data[2:0]);
        ADR_PRESC: div_q   <= wr_data[PRE_W-1:0];
        ADR_CHCTL: begin
          ch_en_q <= wr_data[NUM_CH-1:0];
          dual_q  <= wr_data[CHCTL_DUAL_LSB +: NUM_CH];
        end
        default: ;
      endcase
    end
  end

  pwm_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (tctrl_q.run),
    .clr_i  (tctrl_q.clr),
    .div_i  (div_q),
    .tick_o (tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (tctrl_q.clr),
    .tick_i   (tick),
    .period_i (act[0]),
    .tc_o     (tc),
    .roll_o   (roll)
  );

  pwm_slot_bank #(.CNT_W(CNT_W), .NUM_SLOTS(NUM_SLOTS)) u_slots (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .roll_i  (roll),
    .act_o   (act)
  );

  pwm_edge_gen #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_edges (
    .tc_i     (tc),
    .act_i    (act),
    .pwm_en_i (tctrl_q.pwm_en),
    .ch_en_i  (ch_en_q),
    .dual_i   (dual_q),
    .pwm_o    (pwm_out)
  );

  assign tc_value = tc;

  // R9: a write to an unused address leaves configuration untouched
  a_r9_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr > ADR_ARM) && (wr_addr < ADR_SLOT0))
      |=> ($stable(tctrl_q) && $stable(div_q) && $stable(ch_en_q) && $stable(dual_q)));
  // R7: with PWM mode off every output is low
  a_r7_pwm_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tctrl_q.pwm_en |-> (pwm_out == '0));
endmodule

// File: tb/pwm_match_timer_tb.sv
`timescale 1ns/1ps
module pwm_match_timer_tb_top;
  localparam int NCH = 6;
  localparam int NS  = NCH + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [NCH-1:0] pwm_out;
  logic [15:0] tc_value;

  int errs = 0;
  int checks = 0;
  bit mon_on = 1'b0;

  always #2 clk = ~clk;

  pwm_match_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .tc_value(tc_value)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  int m_pc, m_tc, m_pre, m_lat, m_en, m_dual;
  int m_sh[NS];
  int m_ac[NS];
  bit m_run, m_pen, m_clr;
  bit md_tick, md_roll;
  int md_lat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_tc = 0; m_pre = 0; m_lat = 0; m_en = 0; m_dual = 0;
      m_run = 0; m_pen = 0; m_clr = 0;
      for (int i = 0; i < NS; i++) begin m_sh[i] = 0; m_ac[i] = 0; end
    end else begin
      md_tick = m_run && !m_clr && (m_pc >= m_pre);
      md_roll = md_tick && (m_tc + 1 >= m_ac[0]);
      if (m_clr) m_pc = 0;
      else if (m_run) m_pc = (m_pc >= m_pre) ? 0 : m_pc + 1;
      if (m_clr) m_tc = 0;
      else if (md_roll) m_tc = 0;
      else if (md_tick) m_tc = m_tc + 1;
      md_lat = md_roll ? 0 : m_lat;
      if (md_roll)
        for (int i = 0; i < NS; i++) if (m_lat[i]) m_ac[i] = m_sh[i];
      if (wr_en) begin
        case (wr_addr)
          4'd0: begin m_run = wr_data[0]; m_pen = wr_data[1]; m_clr = wr_data[2]; end
          4'd1: m_pre = int'(wr_data[7:0]);
          4'd2: begin m_en = int'(wr_data[5:0]); m_dual = int'(wr_data[13:8]); end
          4'd3: md_lat = md_lat | int'(wr_data[6:0]);
          default: if (wr_addr >= 4'd8 && int'(wr_addr) < 8 + NS)
                     m_sh[int'(wr_addr) - 8] = int'(wr_data);
        endcase
      end
      m_lat = md_lat;
    end
  end

  function automatic bit exp_out(int k);
    bit lvl;
    if ((k % 2) == 0 && m_dual[k-1]) lvl = (m_tc >= m_ac[k-1]) && (m_tc < m_ac[k]);
    else lvl = (m_tc < m_ac[k]);
    return m_pen && m_en[k-1] && lvl;
  endfunction

  function automatic string tag_of(int k);
    if (!m_pen || !m_en[k-1]) return "R7";
    if (m_dual[k-1]) return "R6";
    if (m_ac[k] == 0 || m_ac[k] >= m_ac[0]) return "R5";
    return "R4";
  endfunction

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      chk(int'(tc_value) == m_tc, "R2 count", int'(tc_value), m_tc);
      for (int k = 1; k <= NCH; k++)
        chk(pwm_out[k-1] == exp_out(k), tag_of(k), int'(pwm_out[k-1]), int'(exp_out(k)));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tc(input int v);
    int n = 0;
    while (int'(tc_value) != v && n < 400) begin @(negedge clk); n++; end
    if (n >= 400) chk(1'b0, "R2 wait", int'(tc_value), v);
  endtask

  task automatic summary_and_end();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary_and_end();
  end

  initial begin
    int held;
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(pwm_out == '0, "R7 reset outputs", int'(pwm_out), 0);
    chk(tc_value == '0, "R2 reset count", int'(tc_value), 0);
    mon_on = 1'b1;

    // configure while stopped: counter must not move
    wr(1, 0); wr(8, 10); wr(9, 4); wr(10, 7);
    wr(2, 16'h003F); wr(3, 7'h07);
    wr(5, 16'hFFFF); wr(15, 16'hFFFF);   // unused addresses
    repeat (4) @(negedge clk);
    chk(tc_value == '0, "R7 stopped", int'(tc_value), 0);
    chk(pwm_out == '0, "R9 unused addr", int'(pwm_out), 0);
    wr(0, 3);

    // R3 shadow without arming
    wait_tc(9); wait_tc(6);
    wr(9, 9);
    wait_tc(9); wait_tc(6);
    chk(pwm_out[0] == 1'b0, "R3 unarmed", int'(pwm_out[0]), 0);
    wr(3, 2);
    wait_tc(8);
    chk(pwm_out[0] == 1'b0, "R3 before wrap", int'(pwm_out[0]), 0);
    wait_tc(6);
    chk(pwm_out[0] == 1'b1, "R3 after wrap", int'(pwm_out[0]), 1);
    wr(9, 2);
    repeat (25) @(negedge clk);
    wait_tc(5);
    chk(pwm_out[0] == 1'b1, "R3 arm cleared", int'(pwm_out[0]), 1);

    // R6 dual edge on channel 2, dual bit on channel 1 ignored
    wr(9, 3); wr(10, 7); wr(2, 16'h033F); wr(3, 6);
    repeat (25) @(negedge clk);
    wait_tc(2);
    chk(pwm_out[1] == 1'b0, "R6 before set", int'(pwm_out[1]), 0);
    chk(pwm_out[0] == 1'b1, "R6 odd ignored", int'(pwm_out[0]), 1);
    wait_tc(3);
    chk(pwm_out[1] == 1'b1, "R6 set edge", int'(pwm_out[1]), 1);
    wait_tc(6);
    chk(pwm_out[1] == 1'b1, "R6 held", int'(pwm_out[1]), 1);
    wait_tc(7);
    chk(pwm_out[1] == 1'b0, "R6 clear edge", int'(pwm_out[1]), 0);
    chk(pwm_out[0] == 1'b0, "R6 odd single", int'(pwm_out[0]), 0);

    // R5 extremes on channel 3
    wr(11, 0); wr(12, 12); wr(2, 16'h003F); wr(3, 7'h18);
    repeat (40) @(negedge clk);
    chk(pwm_out[2] == 1'b0, "R5 zero low", int'(pwm_out[2]), 0);
    chk(pwm_out[3] == 1'b1, "R5 above high", int'(pwm_out[3]), 1);

    // R1 prescale
    wr(1, 3);
    repeat (30) @(negedge clk);
    wait_tc(1); wait_tc(2);
    n = 0;
    while (tc_value == 16'd2 && n < 50) begin @(negedge clk); n++; end
    chk(n == 4, "R1 tick spacing", n, 4);

    // R8 clear held, then release
    wr(0, 7);
    repeat (5) begin
      @(negedge clk);
      chk(tc_value == '0, "R8 held", int'(tc_value), 0);
    end
    wr(0, 3);
    repeat (3) begin
      chk(tc_value == '0, "R8 release", int'(tc_value), 0);
      @(negedge clk);
    end
    @(negedge clk);
    chk(tc_value == 16'd1, "R8 first step", int'(tc_value), 1);

    // R7 pwm mode off and run off
    wr(0, 1);
    repeat (12) begin
      @(negedge clk);
      chk(pwm_out == '0, "R7 pwm off", int'(pwm_out), 0);
    end
    wr(0, 2);
    held = int'(tc_value);
    repeat (10) @(negedge clk);
    chk(int'(tc_value) == held, "R7 run off", int'(tc_value), held);
    wr(0, 3);

    // constrained random phase, checked by the model monitor
    for (int it = 0; it < 160; it++) begin
      int op = int'($urandom_range(0, 9));
      case (op)
        0, 1, 2: wr(9 + int'($urandom_range(0, NCH - 1)), int'($urandom_range(0, 22)));
        3:       wr(8, int'($urandom_range(0, 20)));
        4, 5:    wr(3, int'($urandom_range(0, 127)));
        6:       wr(2, int'($urandom_range(0, 16'hFFFF)) & 16'h3F3F);
        7:       wr(1, int'($urandom_range(0, 3)));
        8:       wr(0, int'($urandom_range(0, 7)));
        default: wr(0, 3);
      endcase
      if (it % 20 == 19) wr(0, 3);
      repeat (int'($urandom_range(3, 50))) @(negedge clk);
    end

    mon_on = 1'b0;
    summary_and_end();
  end
endmodule